// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Request

This block keeps the status flags of a UART-style serial port and turns them into one interrupt request. The transmitter and receiver report five kinds of event as single-cycle pulses: the transmit holding register has emptied, the last frame has finished shifting out, a received byte was lost to overrun, a received byte is waiting, and the line has gone idle. Each pulse sets a sticky flag. The flags sit in the top bits of a byte-wide status register.

Four enable bits in a control register gate the flags. The receive enable covers both the byte-waiting flag and the overrun flag. The OR of all enabled flags is registered once and drives a single interrupt line. Software reads the status byte to find the cause. Software cannot clear a flag by writing it. A flag clears through a two-step sequence: a status read while the flag is set arms the clear, and a later access to the data register carries it out. A data read clears the receive-side flags and a data write clears the transmit-side flags.

The bus is a simple byte port with single-cycle read and write strobes and combinational read data. Reads of the data address return the receiver's byte. Writes to the data address hand the byte to the transmitter with a one-cycle load strobe.

Top module: `sci_flag_ctl`

## Requirements
- R1: After reset, the status register reads 0xC0 (tx-empty and tx-done set, all other flags clear), the control register reads 0x00, and `irq` is low.
- R2: The status register at address 0 has this layout: bit 7 tx-empty, bit 6 tx-done, bit 5 overrun, bit 4 rx-full, bit 3 idle. Bits 2..0 always read zero.
- R3: The control register at address 1 holds the enables in bits 3..0: bit 3 gates tx-empty, bit 2 gates tx-done, bit 1 gates both overrun and rx-full, bit 0 gates idle. Bits 7..4 read zero.
- R4: An event pulse sets its flag on the next clock edge, and the flag stays set until it is cleared.
- R5: A status read arms a clear for each flag that is set during that read. A later data-address read clears the armed rx-full, overrun and idle flags. A later data-address write clears the armed tx-empty and tx-done flags.
- R6: A data-address access that has no earlier arming status read leaves every flag unchanged.
- R7: A flag that sets after the arming status read stays set through the following data access.
- R8: If a set event and a clear of the same flag fall in the same cycle, the flag ends set.
- R9: `irq` is the registered OR of every flag ANDed with its enable. It rises one cycle after an enabled flag sets and falls one cycle after the last enabled flag clears.
- R10: A read of address 2 returns `rx_byte`. A write to address 2 pulses `tx_load` in that cycle, with `tx_byte` equal to the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_tx_empty | input | 1 | Pulse: transmit holding register emptied |
| evt_tx_done | input | 1 | Pulse: transmission complete |
| evt_overrun | input | 1 | Pulse: received byte lost |
| evt_rx_full | input | 1 | Pulse: received byte waiting |
| evt_idle | input | 1 | Pulse: idle line detected |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| rx_byte | input | DATA_W | Receiver byte returned on data reads |
| tx_byte | output | DATA_W | Byte handed to the transmitter |
| tx_load | output | 1 | Transmit load strobe on data writes |
| irq | output | 1 | Shared interrupt request |

## Verification
The checker watches four things on every cycle: that the unused status and control bits read as zero, that an event pulse always leaves its flag set (including when a clear lands in the same cycle), that receive-side flags fall only right after a data read and transmit-side flags only right after a data write, and that `irq` follows the enabled-flag OR with one cycle of delay. Some behaviours depend on the order of earlier accesses and cannot be seen in a single cycle. These are left to the bench scenarios: whether a clear was armed, a data access that arrives with no arming read, and a flag that sets between the read and the access. The bench also sweeps every enable pattern against every single flag to check the gating map.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;
    localparam int NFLAG = 5;
    localparam int NEN   = 4;

    // flag indices; status bit = index + (DATA_W - NFLAG)
    localparam int FL_IDL = 0;
    localparam int FL_RXF = 1;
    localparam int FL_OVR = 2;
    localparam int FL_TXC = 3;
    localparam int FL_TXE = 4;

    // enable indices in the control register
    localparam int EN_IDL = 0;
    localparam int EN_RX  = 1;
    localparam int EN_TXC = 2;
    localparam int EN_TXE = 3;

    typedef logic [NFLAG-1:0] flag_vec_t;
    typedef logic [NEN-1:0]   en_vec_t;

    localparam flag_vec_t RD_CLR_MASK = flag_vec_t'((1 << FL_IDL) | (1 << FL_RXF) | (1 << FL_OVR));
    localparam flag_vec_t WR_CLR_MASK = flag_vec_t'((1 << FL_TXC) | (1 << FL_TXE));
    localparam flag_vec_t FLAG_RESET  = flag_vec_t'((1 << FL_TXC) | (1 << FL_TXE));

    typedef struct packed {
        flag_vec_t flags;
        flag_vec_t arm;
    } bank_st_t;
endpackage

// File: rtl/sci_flag_bank.sv
module sci_flag_bank
    import sci_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  logic      stat_rd_i,
    input  logic      data_rd_i,
    input  logic      data_wr_i,
    output flag_vec_t flags_o
);
    bank_st_t st_d, st_q;
    flag_vec_t clr_mask;
    flag_vec_t clr;

    always_comb begin
        st_d     = st_q;
        clr_mask = (data_rd_i ? RD_CLR_MASK : '0) | (data_wr_i ? WR_CLR_MASK : '0);
        clr      = st_q.arm & clr_mask;
        // arming snapshots the flags visible during the status read
        if (stat_rd_i) begin
            st_d.arm = st_q.arm | st_q.flags;
        end
        st_d.arm   = st_d.arm & ~clr;
        // set wins over clear
        st_d.flags = (st_q.flags & ~clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= FLAG_RESET;
            st_q.arm   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/sci_irq_gate.sv
module sci_irq_gate
    import sci_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t flags_i,
    input  en_vec_t   en_i,
    output logic      irq_o
);
    flag_vec_t gate;
    logic irq_d, irq_q;

    always_comb begin
        gate         = '0;
        gate[FL_TXE] = en_i[EN_TXE];
        gate[FL_TXC] = en_i[EN_TXC];
        gate[FL_OVR] = en_i[EN_RX];
        gate[FL_RXF] = en_i[EN_RX];
        gate[FL_IDL] = en_i[EN_IDL];
        irq_d        = |(flags_i & gate);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/sci_flag_ctl.sv
module sci_flag_ctl
    import sci_flag_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2,
    parameter logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(1),
    parameter logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_tx_empty,
    input  logic              evt_tx_done,
    input  logic              evt_overrun,
    input  logic              evt_rx_full,
    input  logic              evt_idle,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_load,
    output logic              irq
);
    localparam int unsigned FLAG_LSB = DATA_W - NFLAG;
    localparam int unsigned CTL_PAD  = DATA_W - NEN;

    flag_vec_t set_vec;
    flag_vec_t flags_w;
    en_vec_t   en_d, en_q;
    logic stat_rd, ctl_wr, data_rd, data_wr;

    always_comb begin
        set_vec         = '0;
        set_vec[FL_TXE] = evt_tx_empty;
        set_vec[FL_TXC] = evt_tx_done;
        set_vec[FL_OVR] = evt_overrun;
        set_vec[FL_RXF] = evt_rx_full;
        set_vec[FL_IDL] = evt_idle;

        stat_rd = bus_rd && (bus_addr == ADDR_STAT);
        ctl_wr  = bus_wr && (bus_addr == ADDR_CTL);
        data_rd = bus_rd && (bus_addr == ADDR_DATA);
        data_wr = bus_wr && (bus_addr == ADDR_DATA);

        en_d = ctl_wr ? bus_wdata[NEN-1:0] : en_q;

        unique case (bus_addr)
            ADDR_STAT: bus_rdata = {flags_w, {FLAG_LSB{1'b0}}};
            ADDR_CTL:  bus_rdata = {{CTL_PAD{1'b0}}, en_q};
            ADDR_DATA: bus_rdata = rx_byte;
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign tx_byte = bus_wdata;
    assign tx_load = data_wr;

    sci_flag_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .stat_rd_i (stat_rd),
        .data_rd_i (data_rd),
        .data_wr_i (data_wr),
        .flags_o   (flags_w)
    );

    sci_irq_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_w),
        .en_i    (en_q),
        .irq_o   (irq)
    );
endmodule

// File: rtl/sci_flag_chk.sv
module sci_flag_chk
    import sci_flag_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2,
    parameter logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(1),
    parameter logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(2)
) (
    input logic              clk,
    input logic              rst_n,
    input flag_vec_t         ev,
    input flag_vec_t         flags,
    input en_vec_t           en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq
);
    localparam int unsigned FLAG_LSB = DATA_W - NFLAG;

    logic seen;
    flag_vec_t gate;
    logic any_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    always_comb begin
        gate = {en[EN_TXE], en[EN_TXC], en[EN_RX], en[EN_RX], en[EN_IDL]};
        any_en = |(flags & gate);
    end

    assert_stat_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_STAT) |-> (bus_rdata[FLAG_LSB-1:0] == '0));

    assert_ctl_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_CTL) |-> (bus_rdata[DATA_W-1:NEN] == '0));

    // R4 and R8: a set pulse always leaves its flag set
    assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

    assert_rx_fall_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && ((($past(flags) & ~flags) & RD_CLR_MASK) != '0))
        |-> $past(bus_rd && bus_addr == ADDR_DATA));

    assert_tx_fall_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && ((($past(flags) & ~flags) & WR_CLR_MASK) != '0))
        |-> $past(bus_wr && bus_addr == ADDR_DATA));

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_en |=> irq);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> !irq);
endmodule

bind sci_flag_ctl sci_flag_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ADDR_STAT(ADDR_STAT), .ADDR_CTL(ADDR_CTL), .ADDR_DATA(ADDR_DATA)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (set_vec),
    .flags     (flags_w),
    .en        (en_q),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq       (irq)
);

// File: tb/sci_flag_ctl_bench.sv
module sci_flag_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ev = '0;          // {txe, txc, ovr, rxf, idl}
    logic [1:0] addr = '0;
    logic rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0, rdata, rx_byte = 8'h00, tx_byte;
    logic tx_load, irq;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sci_flag_ctl u_sci_flag_ctl (
        .clk(clk), .rst_n(rst_n),
        .evt_tx_empty(ev[4]), .evt_tx_done(ev[3]), .evt_overrun(ev[2]),
        .evt_rx_full(ev[1]), .evt_idle(ev[0]),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .rx_byte(rx_byte), .tx_byte(tx_byte),
        .tx_load(tx_load), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, output logic ld, output logic [7:0] tb);
        addr = a; wdata = d; wr = 1'b1; #1 ld = tx_load; tb = tx_byte;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] m);
        ev = m; @(negedge clk); ev = '0;
    endtask

    task automatic clear_all();
        logic [7:0] d; logic l; logic [7:0] t;
        rd_reg(2'd0, d); rd_reg(2'd2, d); wr_reg(2'd2, 8'h00, l, t);
    endtask

    function automatic int en_of(input int f);
        if (f == 0) return 0;
        if (f <= 2) return 1;
        return f - 1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d, tb; logic ld;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, d); chk("R1 status", d, 8'hC0);
        rd_reg(2'd1, d); chk("R1 ctrl", d, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R3 control readback, upper bits zero
        wr_reg(2'd1, 8'hFF, ld, tb);
        rd_reg(2'd1, d); chk("R3 ctrl readback", d, 8'h0F);

        // R2 R3 R4 R9 sweep: every enable pattern against every flag
        for (int e = 0; e < 16; e++) begin
            for (int f = 0; f < 5; f++) begin
                wr_reg(2'd1, 8'h00, ld, tb);
                clear_all();
                rd_reg(2'd0, d); chk("R5 all cleared", d, 8'h00);
                wr_reg(2'd1, 8'(e), ld, tb);
                pulse(5'(1 << f));
                chk("R9 irq latency", {7'd0, irq}, 8'h00);
                @(negedge clk);
                chk("R3 R9 gated irq", {7'd0, irq}, {7'd0, e[en_of(f)]});
                rd_reg(2'd0, d); chk("R2 R4 flag position", d, 8'((1 << f) << 3));
            end
        end

        // R6 data accesses without an arming read change nothing
        wr_reg(2'd1, 8'h00, ld, tb);
        clear_all();
        pulse(5'b11111);
        rd_reg(2'd2, d);
        wr_reg(2'd2, 8'h33, ld, tb);
        rd_reg(2'd0, d); chk("R6 no arm", d, 8'hF8);

        // R5 read clears rx group only, write clears tx group only
        rd_reg(2'd0, d);
        rd_reg(2'd2, d);
        rd_reg(2'd0, d); chk("R5 read clears rx side", d, 8'hC0);
        wr_reg(2'd2, 8'h44, ld, tb);
        rd_reg(2'd0, d); chk("R5 write clears tx side", d, 8'h00);

        // R7 flag set after the arming read survives
        pulse(5'b00010);
        rd_reg(2'd0, d);
        pulse(5'b00001);
        rx_byte = 8'h5A;
        rd_reg(2'd2, d); chk("R10 rx byte", d, 8'h5A);
        rd_reg(2'd0, d); chk("R7 late flag kept", d, 8'h08);

        // R10 transmit load strobe
        wr_reg(2'd2, 8'hA7, ld, tb);
        chk("R10 tx_load", {7'd0, ld}, 8'h01);
        chk("R10 tx_byte", tb, 8'hA7);

        // R8 set and clear in the same cycle
        clear_all();
        pulse(5'b00010);
        rd_reg(2'd0, d);
        addr = 2'd2; rd = 1'b1; ev = 5'b00010;
        @(negedge clk); rd = 1'b0; ev = '0;
        rd_reg(2'd0, d); chk("R8 set wins", d, 8'h10);

        // R9 deassert one cycle after last enabled flag clears
        wr_reg(2'd1, 8'h02, ld, tb);
        @(negedge clk);
        chk("R9 irq high", {7'd0, irq}, 8'h01);
        rd_reg(2'd0, d);
        rd_reg(2'd2, d);
        chk("R9 irq still high", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R9 irq low", {7'd0, irq}, 8'h00);

        finish_run();
    end
endmodule